// File: doc/BRIEF.md
# Link Pause Resolution Controller

This block settles which directions of Ethernet PAUSE flow control a port uses once link is up. When a start strobe arrives, it looks at the PAUSE and asymmetric-direction bits that the local side and the link partner advertised, the mode that software asked for, a strict-standard flag and the negotiated duplex. From these it produces a final flow-control mode. It then drives a transmit-pause enable and a receive-pause enable from that mode.

When auto-negotiation was not used on the link, a forced path applies the requested mode directly and ignores the advertisements. If auto-negotiation is in use but has not finished, the request is skipped and every output keeps its value.

Alongside the enables, the block publishes the receive FIFO low and high watermark words. These words are zero unless the port may send PAUSE frames. When it may, the low word also carries the XON-enable flag. Each request returns a one-cycle done pulse and a configuration-error flag that are registered with the result.

Top module: `pause_resolver`

## Requirements
- R1: The mode output `mode_o` uses the code 0 for no pause, 1 for receive-only, 2 for transmit-only and 3 for both directions. `tx_pause_en_o` is 1 exactly for modes 2 and 3, and `rx_pause_en_o` is 1 exactly for modes 1 and 3.
- R2: With `an_used_i`=0 (forced path), a start applies the requested mode `req_mode_i` directly. Codes 0..3 are taken as they are, and code 4 ("default") is applied as 3. The advertisement bits, `strict_i` and `full_duplex_i` have no effect on this path.
- R3: On the forced path, a requested code of 5, 6 or 7 sets `cfg_err_o`=1 together with the done pulse. The mode, the enables and the watermarks keep their previous values. Every other start clears `cfg_err_o`.
- R4: On the negotiated path (`an_used_i`=1, `an_done_i`=1, full duplex), when both the local and the partner PAUSE bits are set, the result is 3 if the requested mode is 3 or 4, and 1 otherwise.
- R5: On the negotiated path, two combinations give an asymmetric result. Local PAUSE=0 and ASM=1 with partner PAUSE=1 and ASM=1 gives 2. Local PAUSE=1 and ASM=1 with partner PAUSE=0 and ASM=1 gives 1.
- R6: For every other advertisement combination on the negotiated path, the result is 0 when the requested mode is 0 or 2 or when `strict_i`=1. Otherwise the result is 1; this includes requested codes 5..7.
- R7: On the negotiated path, `full_duplex_i`=0 forces the result to 0 whatever the advertisements and the request are.
- R8: When the resulting mode has transmit pause, `high_wm_o` is `high_wm_cfg_i` zero-extended to 32 bits. In that case `low_wm_o` is `low_wm_cfg_i` in bits 15:0 and `xon_send_i` in bit 31, with all other bits 0. For any other mode, both words are 0.
- R9: With `an_used_i`=1 and `an_done_i`=0, a start changes neither the mode, the enables nor the watermarks. It still gives the done pulse, with `cfg_err_o`=0.
- R10: Results appear on the first rising edge that samples `start_i`=1. `done_o` is 1 for exactly the cycle after each sampled start. Without a start, all outputs other than `done_o` hold their values.
- R11: After reset, the mode, both enables, both watermark words, `done_o` and `cfg_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to resolve or apply |
| an_used_i | input | 1 | 1 when auto-negotiation is in use on the link |
| an_done_i | input | 1 | 1 when auto-negotiation has completed |
| loc_pause_i | input | 1 | Local advertised PAUSE bit |
| loc_asm_i | input | 1 | Local advertised asymmetric-direction bit |
| lp_pause_i | input | 1 | Partner advertised PAUSE bit |
| lp_asm_i | input | 1 | Partner advertised asymmetric-direction bit |
| full_duplex_i | input | 1 | 1 when the negotiated duplex is full |
| strict_i | input | 1 | Strict-standard fallback: no receive-only downgrade |
| req_mode_i | input | 3 | Requested mode: 0..3 as in R1, 4 default, 5..7 invalid |
| xon_send_i | input | 1 | Enables XON sending (flag in the low watermark) |
| low_wm_cfg_i | input | 16 | Low watermark value |
| high_wm_cfg_i | input | 16 | High watermark value |
| mode_o | output | 2 | Active flow-control mode |
| tx_pause_en_o | output | 1 | Transmit-pause enable |
| rx_pause_en_o | output | 1 | Receive-pause enable |
| low_wm_o | output | 32 | Low watermark word with XON flag in bit 31 |
| high_wm_o | output | 32 | High watermark word |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | Invalid forced request, valid with done |

## Verification
The bench targets the following cases.

- A requested receive-only mode after symmetric negotiation. A design that ignores the request would turn on transmit pause here.
- A partner that advertises nothing, with the strict flag off and then on. A design without the downgrade would leave receive pause off, and one that ignores the flag would turn it on.
- Half duplex combined with full symmetric advertisements. A design that misses the override would enable both directions.
- The default code, which must become full on both paths.
- Invalid forced codes. A design that writes them through would corrupt the enables.
- Starts while auto-negotiation is still pending. A design that resolves anyway would change the enables.
- The XON flag and the watermarks across mode changes. A design that keys them to the request instead of the result would publish stale non-zero values.

// File: rtl/pause_pkg.sv
package pause_pkg;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_RX   = 2'd1,
        FC_TX   = 2'd2,
        FC_FULL = 2'd3
    } fc_mode_e;

    localparam int unsigned REQ_W       = 3;
    localparam logic [REQ_W-1:0] REQ_DEFAULT = 3'd4;

    function automatic logic fc_has_tx(input fc_mode_e m);
        return (m == FC_TX) || (m == FC_FULL);
    endfunction

    function automatic logic fc_has_rx(input fc_mode_e m);
        return (m == FC_RX) || (m == FC_FULL);
    endfunction

endpackage

// File: rtl/pause_req_decode.sv
module pause_req_decode
    import pause_pkg::*;
(
    input  logic [REQ_W-1:0] req_i,
    output fc_mode_e         mode_o,
    output logic             valid_o,
    output logic             is_full_o,
    output logic             no_rx_pref_o
);
    always_comb begin
        valid_o = (req_i <= REQ_DEFAULT);
        if (req_i == REQ_DEFAULT) begin
            mode_o = FC_FULL;
        end else begin
            mode_o = fc_mode_e'(req_i[1:0]);
        end
        // Preferences only count for legal codes; others fall to receive-only
        is_full_o    = valid_o && (mode_o == FC_FULL);
        no_rx_pref_o = valid_o && ((mode_o == FC_NONE) || (mode_o == FC_TX));
    end
endmodule

// File: rtl/pause_ad_resolve.sv
module pause_ad_resolve
    import pause_pkg::*;
(
    input  logic     loc_pause_i,
    input  logic     loc_asm_i,
    input  logic     lp_pause_i,
    input  logic     lp_asm_i,
    input  logic     req_full_i,
    input  logic     req_no_rx_i,
    input  logic     strict_i,
    input  logic     full_duplex_i,
    output fc_mode_e mode_o
);
    fc_mode_e adv_mode;
    logic     sym, asym_tx, asym_rx;

    always_comb begin
        sym     = loc_pause_i && lp_pause_i;
        asym_tx = !loc_pause_i && loc_asm_i && lp_pause_i && lp_asm_i;
        asym_rx = loc_pause_i && loc_asm_i && !lp_pause_i && lp_asm_i;

        if (sym) begin
            adv_mode = req_full_i ? FC_FULL : FC_RX;
        end else if (asym_tx) begin
            adv_mode = FC_TX;
        end else if (asym_rx) begin
            adv_mode = FC_RX;
        end else if (req_no_rx_i || strict_i) begin
            adv_mode = FC_NONE;
        end else begin
            adv_mode = FC_RX;
        end

        mode_o = full_duplex_i ? adv_mode : FC_NONE;
    end
endmodule

// File: rtl/pause_wm_gen.sv
module pause_wm_gen
    import pause_pkg::*;
#(
    parameter int unsigned WM_W   = 16,
    parameter int unsigned WORD_W = 32
) (
    input  fc_mode_e          mode_i,
    input  logic              xon_i,
    input  logic [WM_W-1:0]   low_cfg_i,
    input  logic [WM_W-1:0]   high_cfg_i,
    output logic [WORD_W-1:0] low_o,
    output logic [WORD_W-1:0] high_o
);
    localparam int unsigned XON_POS = WORD_W - 1;
    localparam int unsigned PAD_W   = WORD_W - WM_W;

    always_comb begin
        low_o  = '0;
        high_o = '0;
        if (fc_has_tx(mode_i)) begin
            low_o           = {{PAD_W{1'b0}}, low_cfg_i};
            low_o[XON_POS]  = xon_i;
            high_o          = {{PAD_W{1'b0}}, high_cfg_i};
        end
    end
endmodule

// File: rtl/pause_resolver.sv
module pause_resolver
    import pause_pkg::*;
#(
    parameter int unsigned WM_W   = 16,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              an_used_i,
    input  logic              an_done_i,
    input  logic              loc_pause_i,
    input  logic              loc_asm_i,
    input  logic              lp_pause_i,
    input  logic              lp_asm_i,
    input  logic              full_duplex_i,
    input  logic              strict_i,
    input  logic [2:0]        req_mode_i,
    input  logic              xon_send_i,
    input  logic [WM_W-1:0]   low_wm_cfg_i,
    input  logic [WM_W-1:0]   high_wm_cfg_i,
    output logic [1:0]        mode_o,
    output logic              tx_pause_en_o,
    output logic              rx_pause_en_o,
    output logic [WORD_W-1:0] low_wm_o,
    output logic [WORD_W-1:0] high_wm_o,
    output logic              done_o,
    output logic              cfg_err_o
);
    typedef struct packed {
        fc_mode_e          mode;
        logic              tx_en;
        logic              rx_en;
        logic [WORD_W-1:0] low_wm;
        logic [WORD_W-1:0] high_wm;
        logic              done;
        logic              err;
    } state_t;

    state_t state_d, state_q;

    fc_mode_e          forced_mode, neg_mode, next_mode;
    logic              req_valid, req_full, req_no_rx;
    logic              apply;
    logic [WORD_W-1:0] low_calc, high_calc;

    pause_req_decode u_req (
        .req_i        (req_mode_i),
        .mode_o       (forced_mode),
        .valid_o      (req_valid),
        .is_full_o    (req_full),
        .no_rx_pref_o (req_no_rx)
    );

    pause_ad_resolve u_res (
        .loc_pause_i   (loc_pause_i),
        .loc_asm_i     (loc_asm_i),
        .lp_pause_i    (lp_pause_i),
        .lp_asm_i      (lp_asm_i),
        .req_full_i    (req_full),
        .req_no_rx_i   (req_no_rx),
        .strict_i      (strict_i),
        .full_duplex_i (full_duplex_i),
        .mode_o        (neg_mode)
    );

    pause_wm_gen #(
        .WM_W   (WM_W),
        .WORD_W (WORD_W)
    ) u_wm (
        .mode_i     (next_mode),
        .xon_i      (xon_send_i),
        .low_cfg_i  (low_wm_cfg_i),
        .high_cfg_i (high_wm_cfg_i),
        .low_o      (low_calc),
        .high_o     (high_calc)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = start_i;
        apply        = 1'b0;
        next_mode    = state_q.mode;

        if (start_i) begin
            state_d.err = 1'b0;
            if (!an_used_i) begin
                if (req_valid) begin
                    apply     = 1'b1;
                    next_mode = forced_mode;
                end else begin
                    state_d.err = 1'b1;
                end
            end else if (an_done_i) begin
                apply     = 1'b1;
                next_mode = neg_mode;
            end
        end

        if (apply) begin
            state_d.mode    = next_mode;
            state_d.tx_en   = fc_has_tx(next_mode);
            state_d.rx_en   = fc_has_rx(next_mode);
            state_d.low_wm  = low_calc;
            state_d.high_wm = high_calc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode_o        = state_q.mode;
    assign tx_pause_en_o = state_q.tx_en;
    assign rx_pause_en_o = state_q.rx_en;
    assign low_wm_o      = state_q.low_wm;
    assign high_wm_o     = state_q.high_wm;
    assign done_o        = state_q.done;
    assign cfg_err_o     = state_q.err;

    // R10: done is a single pulse per sampled start
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    // R10: outputs hold without a start
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable({mode_o, tx_pause_en_o, rx_pause_en_o, low_wm_o, high_wm_o}));
    // R3: an invalid forced request flags an error and leaves the enables alone
    a_r3_bad_req: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !an_used_i && (req_mode_i > 3'd4)) |=>
        (cfg_err_o && $stable(tx_pause_en_o) && $stable(rx_pause_en_o) && $stable(mode_o)));
    // R7: half duplex on the negotiated path disables pause
    a_r7_half_duplex: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && an_used_i && an_done_i && !full_duplex_i) |=>
        (mode_o == 2'd0 && !tx_pause_en_o && !rx_pause_en_o));
    // R9: pending negotiation changes nothing
    a_r9_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && an_used_i && !an_done_i) |=>
        ($stable(mode_o) && $stable(low_wm_o) && !cfg_err_o));
    // R8: watermarks are zero while transmit pause is off
    a_r8_wm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_pause_en_o |-> (low_wm_o == '0 && high_wm_o == '0));
    // R1: enables follow the published mode
    a_r1_enables: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (tx_pause_en_o == mode_o[1] &&
                    rx_pause_en_o == (mode_o == 2'd1 || mode_o == 2'd3)));
endmodule

// File: tb/sim_pause_resolver.sv
module sim_pause_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, an_used_i = 1'b0, an_done_i = 1'b0;
    logic        loc_pause_i = 1'b0, loc_asm_i = 1'b0, lp_pause_i = 1'b0, lp_asm_i = 1'b0;
    logic        full_duplex_i = 1'b0, strict_i = 1'b0, xon_send_i = 1'b0;
    logic [2:0]  req_mode_i = '0;
    logic [15:0] low_wm_cfg_i = '0, high_wm_cfg_i = '0;
    logic [1:0]  mode_o;
    logic        tx_pause_en_o, rx_pause_en_o, done_o, cfg_err_o;
    logic [31:0] low_wm_o, high_wm_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [1:0]  e_mode = '0;
    logic        e_tx = 1'b0, e_rx = 1'b0, e_done = 1'b0, e_err = 1'b0;
    logic [31:0] e_low = '0, e_high = '0;

    always #2.5 clk = ~clk;

    pause_resolver u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .an_used_i(an_used_i),
        .an_done_i(an_done_i), .loc_pause_i(loc_pause_i), .loc_asm_i(loc_asm_i),
        .lp_pause_i(lp_pause_i), .lp_asm_i(lp_asm_i), .full_duplex_i(full_duplex_i),
        .strict_i(strict_i), .req_mode_i(req_mode_i), .xon_send_i(xon_send_i),
        .low_wm_cfg_i(low_wm_cfg_i), .high_wm_cfg_i(high_wm_cfg_i),
        .mode_o(mode_o), .tx_pause_en_o(tx_pause_en_o), .rx_pause_en_o(rx_pause_en_o),
        .low_wm_o(low_wm_o), .high_wm_o(high_wm_o), .done_o(done_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected negotiated result, written from R4..R7
    function automatic logic [1:0] ref_neg(input logic lp, la, pp, pa, fd, st,
                                           input logic [2:0] req);
        logic [2:0] eff;
        eff = (req == 3'd4) ? 3'd3 : req;
        if (!fd) return 2'd0;
        if (lp && pp) return (eff == 3'd3) ? 2'd3 : 2'd1;
        if (!lp && la && pp && pa) return 2'd2;
        if (lp && la && !pp && pa) return 2'd1;
        if (eff == 3'd0 || eff == 3'd2 || st) return 2'd0;
        return 2'd1;
    endfunction

    task automatic apply(input logic st, au, ad, lp, la, pp, pa, fd, sf, xon,
                         input logic [2:0] req, input logic [15:0] lo, hi);
        string tag;
        logic  upd;
        logic [1:0] m;
        @(negedge clk);
        start_i = st; an_used_i = au; an_done_i = ad;
        loc_pause_i = lp; loc_asm_i = la; lp_pause_i = pp; lp_asm_i = pa;
        full_duplex_i = fd; strict_i = sf; xon_send_i = xon;
        req_mode_i = req; low_wm_cfg_i = lo; high_wm_cfg_i = hi;

        upd = 1'b0; m = e_mode; tag = "R10";
        e_done = st;
        if (st) begin
            e_err = 1'b0;
            if (!au) begin
                if (req <= 3'd4) begin
                    upd = 1'b1; m = (req == 3'd4) ? 2'd3 : req[1:0]; tag = "R2";
                end else begin
                    e_err = 1'b1; tag = "R3";
                end
            end else if (ad) begin
                upd = 1'b1;
                m = ref_neg(lp, la, pp, pa, fd, sf, req);
                if (!fd) tag = "R7";
                else if (lp && pp) tag = "R4";
                else if ((!lp && la && pp && pa) || (lp && la && !pp && pa)) tag = "R5";
                else tag = "R6";
            end else begin
                tag = "R9";
            end
        end
        if (upd) begin
            e_mode = m;
            e_tx   = (m == 2'd2) || (m == 2'd3);
            e_rx   = (m == 2'd1) || (m == 2'd3);
            e_low  = e_tx ? {xon, 15'd0, lo} : 32'd0;
            e_high = e_tx ? {16'd0, hi} : 32'd0;
        end

        @(posedge clk);
        #1;
        start_i = 1'b0;
        check(tag, "mode", {30'd0, mode_o}, {30'd0, e_mode});
        check("R1", "tx_en", {31'd0, tx_pause_en_o}, {31'd0, e_tx});
        check("R1", "rx_en", {31'd0, rx_pause_en_o}, {31'd0, e_rx});
        check("R8", "low_wm", low_wm_o, e_low);
        check("R8", "high_wm", high_wm_o, e_high);
        check("R10", "done", {31'd0, done_o}, {31'd0, e_done});
        check((tag == "R3") ? "R3" : "R3_clear", "cfg_err",
              {31'd0, cfg_err_o}, {31'd0, e_err});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check("R11", "mode", {30'd0, mode_o}, 32'd0);
        check("R11", "enables", {30'd0, tx_pause_en_o, rx_pause_en_o}, 32'd0);
        check("R11", "wm", low_wm_o | high_wm_o, 32'd0);
        check("R11", "done_err", {30'd0, done_o, cfg_err_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: forced codes, including default
        for (int r = 0; r <= 4; r++)
            apply(1, 0, 0, 0, 0, 0, 0, 0, 1, 1, r[2:0], 16'h1234, 16'h5678);
        // R3: invalid forced code keeps full mode
        apply(1, 0, 1, 1, 1, 1, 1, 1, 0, 0, 3'd6, 16'hAAAA, 16'hBBBB);
        // R9: pending negotiation
        apply(1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 3'd0, 16'h0001, 16'h0002);
        // R10: no start holds
        apply(0, 1, 1, 0, 0, 0, 0, 1, 0, 0, 3'd0, 16'h0003, 16'h0004);
        // R4: symmetric with receive-only request, then full
        apply(1, 1, 1, 1, 0, 1, 0, 1, 0, 1, 3'd1, 16'h0010, 16'h0020);
        apply(1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 3'd3, 16'h0011, 16'h0021);
        // R5: asymmetric cases
        apply(1, 1, 1, 0, 1, 1, 1, 1, 0, 0, 3'd1, 16'h0100, 16'h0200);
        apply(1, 1, 1, 1, 1, 0, 1, 1, 0, 0, 3'd3, 16'h0101, 16'h0201);
        // R6: partner advertises nothing, strict off then on
        apply(1, 1, 1, 1, 1, 0, 0, 1, 0, 0, 3'd3, 16'h0300, 16'h0400);
        apply(1, 1, 1, 0, 1, 1, 1, 1, 0, 1, 3'd2, 16'h0301, 16'h0401);
        apply(1, 1, 1, 1, 1, 0, 0, 1, 1, 0, 3'd3, 16'h0302, 16'h0402);
        // R7: half duplex overrides full advertisements
        apply(1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 3'd3, 16'h0500, 16'h0600);
        apply(1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 3'd3, 16'h0501, 16'h0601);

        for (int i = 0; i < 600; i++) begin
            apply(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 5) != 0,
                  $urandom % 2 == 1, $urandom % 2 == 1, $urandom % 2 == 1, $urandom % 2 == 1,
                  ($urandom % 5) != 0, ($urandom % 3) == 0, $urandom % 2 == 1,
                  3'($urandom % 8), 16'($urandom), 16'($urandom));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule